// File: doc/BRIEF.md
# Stored-Pattern Frame Waveform Sequencer

This block plays back one complete frame of a timing waveform, one sample per clock, from an on-chip pattern memory. Every stored word is `LEVEL_W + 1` bits wide. The low `LEVEL_W` bits (7 by default) are an output level that drives an external resistor-ladder DAC. The top bit marks the last sample of the frame. Sync, blanking and every other timing feature of the picture come from the same memory read, so their edges stay aligned to one another.

An address counter steps through the memory. When a word whose top bit is set has been read, the counter goes back to zero. The frame length is therefore set by the stored data and not by a fixed terminal count. If no word is marked, the counter wraps through the whole address space.

The pattern is loaded through a simple write port. While the run enable is low, the sequencer holds at address 0 and its outputs stay at zero. A full two-field frame at about 6.4 MHz needs `ADDR_W = 18`. The default is smaller so that the memory stays modest in size.

The control is a two-state machine:
- `SQ_IDLE`: address held at 0, outputs at zero.
- `SQ_RUN`: address advances each clock.

It has two transitions:
- `START` (`SQ_IDLE` to `SQ_RUN`) when `run_en` is sampled high.
- `HALT` (`SQ_RUN` to `SQ_IDLE`) when `run_en` is sampled low.

Top module: `wave_pattern_seq`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `level_o` is 0 and `frame_start_o` is 0.
- R2: While `run_en` is low, the machine stays in `SQ_IDLE`, the address is held at 0, and from the second rising edge after `run_en` falls, `level_o` is 0 and `frame_start_o` is 0.
- R3: On `START`, memory words play in address order. The level bits [`LEVEL_W-1`:0] of word n appear on `level_o` after the (n+2)th rising edge counted from the edge that first samples `run_en` high. Before that, `level_o` is 0.
- R4: A word whose bit `LEVEL_W` (bit 7 by default) is 1 is the last word of the frame. The sample after it is word 0, so a mark at address k gives a frame of k+1 samples that repeats.
- R5: When no word carries the end bit, the address runs from 0 to 2^`ADDR_W`-1 and then wraps to 0.
- R6: `frame_start_o` is high for exactly those clocks in which `level_o` shows word 0 while running.
- R7: With `wr_en` high at a rising edge, `wr_data` is stored at `wr_addr`. A later playback of that address outputs the new level.
- R8: A `HALT` in the middle of a frame ends playback, and the next `START` begins again from word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Playback enable; low holds at address 0 |
| wr_en | input | 1 | Pattern memory write strobe |
| wr_addr | input | ADDR_W | Pattern memory write address |
| wr_data | input | LEVEL_W+1 | Word to store: end bit on top, level below |
| level_o | output | LEVEL_W | Registered level for the ladder DAC |
| frame_start_o | output | 1 | High while word 0 is on `level_o` |

## Verification
The assertions assume that `run_en` is low throughout reset. They also assume that memory words which playback can reach have been written before `run_en` rises, so the end bit the counter reacts to is never unknown. The stimulus loads every address a scenario can reach while the sequencer is idle. It raises `run_en` only a few clocks after the last write, and it leaves the write port quiet during playback. Reloads happen only after a `HALT`.

// File: rtl/wave_seq_pkg.sv
package wave_seq_pkg;

    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/pattern_ram.sv
module pattern_ram #(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Synchronous read; a read that coincides with a write returns the old word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= store[raddr];
        end
    end

endmodule

// File: rtl/frame_seq_fsm.sv
module frame_seq_fsm
    import wave_seq_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              last_word,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] addr_next,
    output logic              running
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_next;
        end
    end

    always_comb begin
        state_d   = state_q;
        addr_next = '0;
        unique case (state_q)
            SQ_IDLE: begin
                if (run_en) begin
                    state_d = SQ_RUN;     // START
                end
            end
            SQ_RUN: begin
                if (!run_en) begin
                    state_d = SQ_IDLE;    // HALT
                end else if (!last_word) begin
                    addr_next = addr_q + 1'b1;  // natural wrap at 2^ADDR_W
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    assign running = (state_q == SQ_RUN);

    a_r4_reload_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_en && last_word) |=> (addr_q == '0));

    a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_en && !last_word) |=> (addr_q == $past(addr_q) + 1'b1));

    a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (addr_q == '0 && !running));

endmodule

// File: rtl/level_out_reg.sv
module level_out_reg #(
    parameter int ADDR_W  = 10,
    parameter int LEVEL_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               running,
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [LEVEL_W-1:0] cur_level,
    output logic [LEVEL_W-1:0] level_o,
    output logic               frame_start_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_o       <= '0;
            frame_start_o <= 1'b0;
        end else begin
            level_o       <= running ? cur_level : '0;
            frame_start_o <= running && (cur_addr == '0);
        end
    end

    a_r6_start_marks_word0: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> ($past(running) && $past(cur_addr) == '0));

    a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (level_o == '0 && !frame_start_o));

endmodule

// File: rtl/wave_pattern_seq.sv
module wave_pattern_seq #(
    parameter int ADDR_W  = 10,
    parameter int LEVEL_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [LEVEL_W:0]   wr_data,
    output logic [LEVEL_W-1:0] level_o,
    output logic               frame_start_o
);
    localparam int WORD_W = LEVEL_W + 1;

    logic [WORD_W-1:0] rd_word;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_next;
    logic              running;

    pattern_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (addr_next),
        .rdata (rd_word)
    );

    frame_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .last_word (rd_word[LEVEL_W]),
        .addr_q    (addr_q),
        .addr_next (addr_next),
        .running   (running)
    );

    level_out_reg #(.ADDR_W(ADDR_W), .LEVEL_W(LEVEL_W)) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .running       (running),
        .cur_addr      (addr_q),
        .cur_level     (rd_word[LEVEL_W-1:0]),
        .level_o       (level_o),
        .frame_start_o (frame_start_o)
    );

    a_r2_level_zero_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!run_en) && !run_en) |=> (level_o == '0 && !frame_start_o));

endmodule

// File: tb/wave_pattern_seq_test.sv
module wave_pattern_seq_test;
    localparam int AW = 6;
    localparam int LW = 7;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [LW:0]   wr_data = '0;
    logic [LW-1:0] level_o;
    logic          frame_start_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wave_pattern_seq #(.ADDR_W(AW), .LEVEL_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .level_o(level_o), .frame_start_o(frame_start_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_word(input int a, input int lvl, input bit last);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = {last, LW'(lvl)};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Raise run_en; after this returns the next negedge shows word 0.
    task automatic start_run();
        @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
        check("R3 pre-output zero", int'(level_o), 0);
    endtask

    task automatic stop_run();
        @(negedge clk);
        run_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        check("R1 level in reset", int'(level_o), 0);
        check("R1 strobe in reset", int'(frame_start_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 level after reset", int'(level_o), 0);
        check("R1 strobe after reset", int'(frame_start_o), 0);
    endtask

    task automatic t_idle();
        write_word(0, 99, 1'b1);
        repeat (6) begin
            @(negedge clk);
            check("R2 idle level", int'(level_o), 0);
            check("R2 idle strobe", int'(frame_start_o), 0);
        end
    endtask

    // Short frame: words 0..4, end bit on word 4 (R4), levels 10..14.
    task automatic t_short_frame();
        for (int i = 0; i < 5; i++) write_word(i, 10 + i, i == 4);
        write_word(5, 77, 1'b0);
        start_run();
        for (int j = 0; j < 15; j++) begin
            @(negedge clk);
            check("R3 R4 frame level", int'(level_o), 10 + (j % 5));
            check("R6 frame strobe", int'(frame_start_o), int'((j % 5) == 0));
        end
        stop_run();
    endtask

    // One-word frame: end bit on word 0, strobe every clock (R4, R6).
    task automatic t_single_word();
        write_word(0, 42, 1'b1);
        start_run();
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            check("R4 single word level", int'(level_o), 42);
            check("R6 single word strobe", int'(frame_start_o), 1);
        end
        stop_run();
    endtask

    // No end bit anywhere: full wrap (R5).
    task automatic t_wrap();
        for (int i = 0; i < DEPTH; i++) write_word(i, (i * 3 + 1) % 128, 1'b0);
        start_run();
        for (int j = 0; j < DEPTH + 6; j++) begin
            @(negedge clk);
            check("R5 wrap level", int'(level_o), ((j % DEPTH) * 3 + 1) % 128);
            check("R5 wrap strobe", int'(frame_start_o), int'((j % DEPTH) == 0));
        end
        stop_run();
    endtask

    // Halt mid-frame, then restart from word 0 (R8, R2).
    task automatic t_halt_restart();
        for (int i = 0; i < 8; i++) write_word(i, 50 + i, i == 7);
        start_run();
        repeat (4) @(negedge clk);
        check("R8 before halt", int'(level_o), 53);
        run_en = 1'b0;
        @(negedge clk);
        check("R8 last sample before halt", int'(level_o), 54);
        @(negedge clk);
        check("R2 R8 level after halt", int'(level_o), 0);
        check("R2 R8 strobe after halt", int'(frame_start_o), 0);
        start_run();
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            check("R8 restart level", int'(level_o), 50 + j);
        end
        stop_run();
    endtask

    // Rewrite a word and see the new level on playback (R7).
    task automatic t_rewrite();
        write_word(2, 111, 1'b0);
        write_word(3, 5, 1'b1);
        start_run();
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            check("R7 rewritten level", int'(level_o),
                  (j % 4) == 2 ? 111 : (j % 4) == 3 ? 5 : 50 + (j % 4));
        end
        stop_run();
    endtask

    initial begin
        t_reset();
        t_idle();
        t_short_frame();
        t_single_word();
        t_wrap();
        t_halt_restart();
        t_rewrite();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule